// File: doc/BRIEF.md
# SMBus Host Register File and Transaction Dispatcher

This block is the software-facing side of an SMBus host controller. A byte-wide register bus reaches a status register, a control register, a command byte, a target-address byte, two data bytes, a block-data byte and a small auxiliary control field. Software loads the registers and then writes the control register with its start bit set. The block decodes the protocol field and issues a single request to a downstream transaction engine. The engine handles the wire-level signalling. When the engine answers, the block stores any returned bytes in the data registers, updates the status flags and raises a level interrupt if interrupts are enabled.

Start can behave in two ways. With interrupts enabled, the request goes out on the clock edge that accepts the control write. With interrupts disabled, the write only raises host-busy and arms a pending flag. The request then goes out on the edge of the next status-register read. That read still returns the busy value. A kill written to the control register drops the request in flight, and the block ignores any late answer from the engine.

Top module: `smb_host_regs`

## Requirements
- R1: Register offsets are 0x3 command, 0x4 address, 0x5 data0, 0x6 data1, 0x7 block data and 0xD auxiliary (bits 1:0 kept, others read 0). Each of these reads back the last value written. Offsets other than 0x0, 0x2, 0x3 to 0x7 and 0xD read as zero, and writes to them change nothing.
- R2: Control is offset 0x2: bit0 interrupt enable, bit1 kill, bits 4:2 protocol, bit6 start. A control read returns only bits 4:0, so bits 7:5 read as zero.
- R3: Status is offset 0x0: bit0 busy, bit1 done, bit2 device error, bit4 failed, bit7 byte done. Writing a 1 to any bit from 1 to 7 clears that bit. Bit0 cannot be cleared by software. If a completion sets a bit on the same edge that a status write clears it, the bit stays set.
- R4: Writing start with interrupt enable set and kill clear issues a one-cycle request on the next cycle. The request carries: protocol = bits 4:2, target = address bits 7:1, read flag = address bit0 (forced to 1 for protocol 6), command, write word {data1, data0} and the block-data byte. Busy stays set until the engine answers.
- R5: An engine answer without error sets done and clears busy. An answer with error sets device error and clears busy.
- R6: On success, a read with protocol 1 or 2 stores the low return byte in data0. Protocol 3 as a read, and protocol 4 always, store the low byte in data0 and the high byte in data1. Protocol 5 as a read, and protocol 6 always, store the low byte in block data and the high byte (the count) in data0. Protocols 5 and 6 also set byte done.
- R7: Protocol code 7 issues no request and sets device error.
- R8: While device error is set, a start issues no request and leaves device error set. Busy ends up clear.
- R9: With interrupt enable clear, start issues no request and sets busy. The next status read returns the value with busy set and starts the request on that edge.
- R10: Writing kill sets failed, clears busy, cancels a pending deferred start and pulses the engine abort if a request was outstanding. An engine answer that arrives later changes nothing. Kill takes priority over a start in the same write.
- R11: The interrupt is high exactly when interrupt enable is set and any status bit from 1 to 7 is set.
- R12: After reset, every register and the pending flag are zero, and no request, abort or interrupt is driven.
- R13: A start written while a request is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; side effects occur at the clock edge |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq | output | 1 | Level interrupt |
| eng_req | output | 1 | One-cycle request to the transaction engine |
| eng_proto | output | 3 | Protocol code of the request |
| eng_taddr | output | 7 | 7-bit target address |
| eng_rnw | output | 1 | Read flag |
| eng_cmd | output | 8 | Command byte |
| eng_wdata | output | 16 | Write word {data1, data0}; low byte doubles as block length |
| eng_blk | output | 8 | Block-data byte |
| eng_abort | output | 1 | One-cycle abort of the outstanding request |
| eng_done | input | 1 | Engine answer strobe |
| eng_err | input | 1 | Answer carries an error |
| eng_rdata | input | 16 | Returned word, high byte and low byte |

## Verification
The collision that matters most is an engine answer landing on the same edge as a software write to status. The answer wants to set done while the write-one-to-clear wants to clear it. The bench raises eng_done and a status write of 0x02 in one cycle and expects done to survive with busy cleared. A second collision is a status write while busy is set: the write of 0xFF must leave busy at 1. Kill and start in one control write, and kill against a pending deferred start, are checked to produce no request at the engine port.

// File: rtl/smb_host_pkg.sv
// Shared offsets, bit positions and protocol codes of the SMBus host registers.
// Assumes a byte-wide register bus; offsets are 4 bits, zero-extended by users.
package smb_host_pkg;
    localparam int BYTE_W = 8;

    localparam logic [3:0] OFS_STS = 4'h0;
    localparam logic [3:0] OFS_CTL = 4'h2;
    localparam logic [3:0] OFS_CMD = 4'h3;
    localparam logic [3:0] OFS_ADR = 4'h4;
    localparam logic [3:0] OFS_D0  = 4'h5;
    localparam logic [3:0] OFS_D1  = 4'h6;
    localparam logic [3:0] OFS_BLK = 4'h7;
    localparam logic [3:0] OFS_AUX = 4'hD;

    localparam int ST_BUSY   = 0;
    localparam int ST_DONE   = 1;
    localparam int ST_DEVERR = 2;
    localparam int ST_FAILED = 4;
    localparam int ST_BYTEDN = 7;

    localparam int CT_IEN   = 0;
    localparam int CT_KILL  = 1;
    localparam int CT_PLO   = 2;
    localparam int CT_PHI   = 4;
    localparam int CT_START = 6;

    localparam logic [2:0] PR_BYTE   = 3'd1;
    localparam logic [2:0] PR_BDATA  = 3'd2;
    localparam logic [2:0] PR_WORD   = 3'd3;
    localparam logic [2:0] PR_PCALL  = 3'd4;
    localparam logic [2:0] PR_BLOCK  = 3'd5;
    localparam logic [2:0] PR_I2CRD  = 3'd6;
    localparam logic [2:0] PR_RSVD   = 3'd7;
endpackage

// File: rtl/smb_status_reg.sv
// Status flag register: busy in bit 0 follows set/clear strobes with set
// winning; bits 7:1 are write-one-to-clear with hardware sets winning.
// Assumes set strobes arrive as a mask aligned to the status bit positions.
module smb_status_reg
    import smb_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic [BYTE_W-1:0] clr_mask,
    input  logic [BYTE_W-1:0] set_mask,
    input  logic              busy_set,
    input  logic              busy_clr,
    output logic [BYTE_W-1:0] stat
);
    logic [BYTE_W-1:0] clr_eff;

    // Software clear applies only while a status write is present.
    always_comb clr_eff = clr_en ? clr_mask : '0;

    // Flag update: busy by strobes, other bits clear-then-set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '0;
        end else begin
            for (int b = 1; b < BYTE_W; b++) begin
                stat[b] <= (stat[b] & ~clr_eff[b]) | set_mask[b];
            end
            if (busy_set)
                stat[ST_BUSY] <= 1'b1;
            else if (busy_clr)
                stat[ST_BUSY] <= 1'b0;
        end
    end
endmodule

// File: rtl/smb_dispatch.sv
// Transaction dispatcher: accepts a run strobe, refuses it on a latched
// device error or a reserved protocol, otherwise latches the request fields,
// pulses eng_req and waits for the engine answer. Kill drops the wait.
// Assumes the engine answers at most once per request, any cycle after it.
module smb_dispatch
    import smb_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_req,
    input  logic [2:0]        run_proto,
    input  logic              dev_err_now,
    input  logic              kill,
    input  logic [BYTE_W-1:0] adr_reg,
    input  logic [BYTE_W-1:0] cmd_reg,
    input  logic [BYTE_W-1:0] d0_reg,
    input  logic [BYTE_W-1:0] d1_reg,
    input  logic [BYTE_W-1:0] blk_reg,
    input  logic              eng_done,
    input  logic              eng_err,
    input  logic [2*BYTE_W-1:0] eng_rdata,
    output logic              issue,
    output logic              refuse,
    output logic              outstanding,
    output logic              fin_ok,
    output logic              fin_err,
    output logic              fin_block,
    output logic              cap_d0_en,
    output logic              cap_d1_en,
    output logic              cap_blk_en,
    output logic [BYTE_W-1:0] cap_d0,
    output logic [BYTE_W-1:0] cap_d1,
    output logic [BYTE_W-1:0] cap_blk,
    output logic              eng_req,
    output logic [2:0]        eng_proto,
    output logic [6:0]        eng_taddr,
    output logic              eng_rnw,
    output logic [BYTE_W-1:0] eng_cmd,
    output logic [2*BYTE_W-1:0] eng_wdata,
    output logic [BYTE_W-1:0] eng_blk,
    output logic              eng_abort
);
    logic accept;
    logic is_block;

    // Decide whether a run strobe becomes a request or a device error.
    always_comb begin
        accept = run_req && !outstanding && !kill;
        refuse = accept && (dev_err_now || run_proto == PR_RSVD);
        issue  = accept && !refuse;
    end

    // Completion of the outstanding request, unless killed this cycle.
    always_comb begin
        fin_ok  = outstanding && eng_done && !eng_err && !kill;
        fin_err = outstanding && eng_done &&  eng_err && !kill;
    end

    // Outstanding flag and one-cycle request/abort pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= 1'b0;
            eng_req     <= 1'b0;
            eng_abort   <= 1'b0;
        end else begin
            eng_req   <= issue;
            eng_abort <= kill && outstanding;
            if (issue)
                outstanding <= 1'b1;
            else if (kill || (outstanding && eng_done))
                outstanding <= 1'b0;
        end
    end

    // Request fields are captured once, on the issuing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_proto <= '0;
            eng_taddr <= '0;
            eng_rnw   <= 1'b0;
            eng_cmd   <= '0;
            eng_wdata <= '0;
            eng_blk   <= '0;
        end else if (issue) begin
            eng_proto <= run_proto;
            eng_taddr <= adr_reg[BYTE_W-1:1];
            eng_rnw   <= adr_reg[0] || (run_proto == PR_I2CRD);
            eng_cmd   <= cmd_reg;
            eng_wdata <= {d1_reg, d0_reg};
            eng_blk   <= blk_reg;
        end
    end

    // Which data registers take the returned word, by latched protocol.
    always_comb begin
        cap_d0_en  = 1'b0;
        cap_d1_en  = 1'b0;
        cap_blk_en = 1'b0;
        is_block   = (eng_proto == PR_BLOCK) || (eng_proto == PR_I2CRD);
        if (fin_ok) begin
            case (eng_proto)
                PR_BYTE, PR_BDATA: cap_d0_en = eng_rnw;
                PR_WORD: begin
                    cap_d0_en = eng_rnw;
                    cap_d1_en = eng_rnw;
                end
                PR_PCALL: begin
                    cap_d0_en = 1'b1;
                    cap_d1_en = 1'b1;
                end
                PR_BLOCK, PR_I2CRD: begin
                    cap_d0_en  = eng_rnw;
                    cap_blk_en = eng_rnw;
                end
                default: ;
            endcase
        end
        fin_block = fin_ok && is_block;
        cap_d0    = is_block ? eng_rdata[2*BYTE_W-1:BYTE_W] : eng_rdata[BYTE_W-1:0];
        cap_d1    = eng_rdata[2*BYTE_W-1:BYTE_W];
        cap_blk   = eng_rdata[BYTE_W-1:0];
    end
endmodule

// File: rtl/smb_read_mux.sv
// Register read multiplexer: returns the addressed register, control masked
// to its low five bits, zero for unmapped offsets.
// Assumes the auxiliary field is narrower than a byte.
module smb_read_mux
    import smb_host_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int AUX_W  = 2,
    parameter int CTL_W  = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] stat,
    input  logic [CTL_W-1:0]  ctl,
    input  logic [BYTE_W-1:0] cmd,
    input  logic [BYTE_W-1:0] adr,
    input  logic [BYTE_W-1:0] d0,
    input  logic [BYTE_W-1:0] d1,
    input  logic [BYTE_W-1:0] blk,
    input  logic [AUX_W-1:0]  aux,
    output logic [BYTE_W-1:0] rdata
);
    // Offset decode to a byte.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_STS)) rdata = stat;
        else if (addr == ADDR_W'(OFS_CTL)) rdata = BYTE_W'(ctl);
        else if (addr == ADDR_W'(OFS_CMD)) rdata = cmd;
        else if (addr == ADDR_W'(OFS_ADR)) rdata = adr;
        else if (addr == ADDR_W'(OFS_D0))  rdata = d0;
        else if (addr == ADDR_W'(OFS_D1))  rdata = d1;
        else if (addr == ADDR_W'(OFS_BLK)) rdata = blk;
        else if (addr == ADDR_W'(OFS_AUX)) rdata = BYTE_W'(aux);
    end
endmodule

// File: rtl/smb_host_regs.sv
// SMBus host register file and dispatcher top. Decodes register accesses,
// holds the software registers and the deferred-start flag, and ties the
// status register, dispatcher and read multiplexer together.
// Assumes reg_wr and reg_rd are not asserted in the same cycle.
module smb_host_regs
    import smb_host_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int AUX_W  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    output logic                irq,
    output logic                eng_req,
    output logic [2:0]          eng_proto,
    output logic [6:0]          eng_taddr,
    output logic                eng_rnw,
    output logic [7:0]          eng_cmd,
    output logic [15:0]         eng_wdata,
    output logic [7:0]          eng_blk,
    output logic                eng_abort,
    input  logic                eng_done,
    input  logic                eng_err,
    input  logic [15:0]         eng_rdata
);
    localparam int CTL_W = CT_PHI + 1;

    logic [CTL_W-1:0]  ctl_q;
    logic [BYTE_W-1:0] cmd_q, adr_q, d0_q, d1_q, blk_q;
    logic [AUX_W-1:0]  aux_q;
    logic              pending_q;
    logic [BYTE_W-1:0] stat;

    logic wr_sts, wr_ctl, wr_cmd, wr_adr, wr_d0, wr_d1, wr_blk, wr_aux, rd_sts;
    logic start_wr, kill_wr, imm_run, def_arm, def_run, run_req;
    logic [2:0] run_proto;
    logic [BYTE_W-1:0] set_mask;
    logic busy_set, busy_clr;

    logic issue, refuse, outstanding, fin_ok, fin_err, fin_block;
    logic cap_d0_en, cap_d1_en, cap_blk_en;
    logic [BYTE_W-1:0] cap_d0, cap_d1, cap_blk;

    // Address decode of register strobes.
    always_comb begin
        wr_sts = reg_wr && reg_addr == ADDR_W'(OFS_STS);
        wr_ctl = reg_wr && reg_addr == ADDR_W'(OFS_CTL);
        wr_cmd = reg_wr && reg_addr == ADDR_W'(OFS_CMD);
        wr_adr = reg_wr && reg_addr == ADDR_W'(OFS_ADR);
        wr_d0  = reg_wr && reg_addr == ADDR_W'(OFS_D0);
        wr_d1  = reg_wr && reg_addr == ADDR_W'(OFS_D1);
        wr_blk = reg_wr && reg_addr == ADDR_W'(OFS_BLK);
        wr_aux = reg_wr && reg_addr == ADDR_W'(OFS_AUX);
        rd_sts = reg_rd && reg_addr == ADDR_W'(OFS_STS);
    end

    // Start, kill and deferred-start decisions for this cycle.
    always_comb begin
        start_wr  = wr_ctl && reg_wdata[CT_START];
        kill_wr   = wr_ctl && reg_wdata[CT_KILL];
        imm_run   = start_wr && reg_wdata[CT_IEN] && !kill_wr;
        def_arm   = start_wr && !reg_wdata[CT_IEN] && !kill_wr && !outstanding;
        def_run   = rd_sts && pending_q;
        run_req   = imm_run || def_run;
        run_proto = imm_run ? reg_wdata[CT_PHI:CT_PLO] : ctl_q[CT_PHI:CT_PLO];
    end

    // Status set sources and busy strobes.
    always_comb begin
        set_mask            = '0;
        set_mask[ST_DONE]   = fin_ok;
        set_mask[ST_DEVERR] = fin_err || refuse;
        set_mask[ST_FAILED] = kill_wr;
        set_mask[ST_BYTEDN] = fin_block;
        busy_set            = issue || def_arm;
        busy_clr            = def_run || fin_ok || fin_err || kill_wr;
    end

    // Deferred-start flag: armed by a start without interrupts, used by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending_q <= 1'b0;
        else if (kill_wr || def_run || imm_run)
            pending_q <= 1'b0;
        else if (def_arm)
            pending_q <= 1'b1;
    end

    // Control register keeps bits 4:0; start is never stored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (wr_ctl)
            ctl_q <= reg_wdata[CTL_W-1:0];
    end

    // Plain software registers: command, address, auxiliary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
            adr_q <= '0;
            aux_q <= '0;
        end else begin
            if (wr_cmd) cmd_q <= reg_wdata;
            if (wr_adr) adr_q <= reg_wdata;
            if (wr_aux) aux_q <= reg_wdata[AUX_W-1:0];
        end
    end

    // Data registers: engine results take priority over software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d0_q  <= '0;
            d1_q  <= '0;
            blk_q <= '0;
        end else begin
            if (cap_d0_en)      d0_q <= cap_d0;
            else if (wr_d0)     d0_q <= reg_wdata;
            if (cap_d1_en)      d1_q <= cap_d1;
            else if (wr_d1)     d1_q <= reg_wdata;
            if (cap_blk_en)     blk_q <= cap_blk;
            else if (wr_blk)    blk_q <= reg_wdata;
        end
    end

    // Level interrupt from enable and any non-busy flag.
    always_comb irq = ctl_q[CT_IEN] && (stat[BYTE_W-1:1] != '0);

    smb_status_reg u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (wr_sts),
        .clr_mask (reg_wdata),
        .set_mask (set_mask),
        .busy_set (busy_set),
        .busy_clr (busy_clr),
        .stat     (stat)
    );

    smb_dispatch u_dispatch (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_req     (run_req),
        .run_proto   (run_proto),
        .dev_err_now (stat[ST_DEVERR]),
        .kill        (kill_wr),
        .adr_reg     (adr_q),
        .cmd_reg     (cmd_q),
        .d0_reg      (d0_q),
        .d1_reg      (d1_q),
        .blk_reg     (blk_q),
        .eng_done    (eng_done),
        .eng_err     (eng_err),
        .eng_rdata   (eng_rdata),
        .issue       (issue),
        .refuse      (refuse),
        .outstanding (outstanding),
        .fin_ok      (fin_ok),
        .fin_err     (fin_err),
        .fin_block   (fin_block),
        .cap_d0_en   (cap_d0_en),
        .cap_d1_en   (cap_d1_en),
        .cap_blk_en  (cap_blk_en),
        .cap_d0      (cap_d0),
        .cap_d1      (cap_d1),
        .cap_blk     (cap_blk),
        .eng_req     (eng_req),
        .eng_proto   (eng_proto),
        .eng_taddr   (eng_taddr),
        .eng_rnw     (eng_rnw),
        .eng_cmd     (eng_cmd),
        .eng_wdata   (eng_wdata),
        .eng_blk     (eng_blk),
        .eng_abort   (eng_abort)
    );

    smb_read_mux #(
        .ADDR_W (ADDR_W),
        .AUX_W  (AUX_W),
        .CTL_W  (CTL_W)
    ) u_rmux (
        .addr  (reg_addr),
        .stat  (stat),
        .ctl   (ctl_q),
        .cmd   (cmd_q),
        .adr   (adr_q),
        .d0    (d0_q),
        .d1    (d1_q),
        .blk   (blk_q),
        .aux   (aux_q),
        .rdata (reg_rdata)
    );
endmodule

// File: rtl/smb_host_regs_chk.sv
// Property checker for smb_host_regs, attached by bind. Observes the register
// bus, the engine port and the status register.
// Assumes reg_wr and reg_rd are exclusive, as the top does.
module smb_host_regs_chk
    import smb_host_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_wdata,
    input logic [7:0]        reg_rdata,
    input logic              irq,
    input logic              eng_req,
    input logic              eng_done,
    input logic [7:0]        stat
);
    logic ctl_wr, sts_wr, ctl_rd;

    // Bus strobes seen by the properties.
    always_comb begin
        ctl_wr = reg_wr && reg_addr == ADDR_W'(OFS_CTL);
        sts_wr = reg_wr && reg_addr == ADDR_W'(OFS_STS);
        ctl_rd = reg_rd && reg_addr == ADDR_W'(OFS_CTL);
    end

    // R2: control read never shows bits 7:5
    a_r2_ctl_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd |-> reg_rdata[7:5] == 3'b000);

    // R3: a status write cannot drop busy when nothing else ends it
    a_r3_busy_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && !reg_rd && stat[ST_BUSY] && !eng_done) |=> stat[ST_BUSY]);

    // R4: request is a single-cycle pulse
    a_r4_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |=> !eng_req);

    // R8: start while device error is set issues nothing
    a_r8_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && reg_wdata[CT_START] && reg_wdata[CT_IEN] && !reg_wdata[CT_KILL]
         && stat[ST_DEVERR]) |=> !eng_req);

    // R9: start without interrupts only raises busy
    a_r9_deferred: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && reg_wdata[CT_START] && !reg_wdata[CT_IEN] && !reg_wdata[CT_KILL]
         && !stat[ST_BUSY]) |=> (stat[ST_BUSY] && !eng_req));

    // R10: kill leaves failed set, busy clear and no request
    a_r10_kill: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && reg_wdata[CT_KILL]) |=> (stat[ST_FAILED] && !stat[ST_BUSY] && !eng_req));

    // R11: with interrupts reading back disabled, no interrupt
    a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd && !reg_rdata[CT_IEN]) |-> !irq);
endmodule

bind smb_host_regs smb_host_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .eng_req   (eng_req),
    .eng_done  (eng_done),
    .stat      (stat)
);

// File: tb/smb_host_regs_test.sv
`timescale 1ns/100ps
// Bench for smb_host_regs: sweeps offsets and all protocol/read-flag pairs,
// then walks the collision, error, deferred and kill corners.
module smb_host_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq, eng_req, eng_rnw, eng_abort;
    logic [2:0]  eng_proto;
    logic [6:0]  eng_taddr;
    logic [7:0]  eng_cmd, eng_blk;
    logic [15:0] eng_wdata;
    logic        eng_done = 1'b0, eng_err = 1'b0;
    logic [15:0] eng_rdata = '0;

    int checks = 0, failures = 0;
    logic finished = 1'b0;

    always #2.5 clk = ~clk;

    smb_host_regs uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .eng_req(eng_req), .eng_proto(eng_proto),
        .eng_taddr(eng_taddr), .eng_rnw(eng_rnw), .eng_cmd(eng_cmd),
        .eng_wdata(eng_wdata), .eng_blk(eng_blk), .eng_abort(eng_abort),
        .eng_done(eng_done), .eng_err(eng_err), .eng_rdata(eng_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic rdchk(input string tag, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(tag, {24'd0, v}, {24'd0, exp});
    endtask

    task automatic respond(input logic err, input logic [15:0] rv);
        @(negedge clk); eng_done = 1'b1; eng_err = err; eng_rdata = rv;
        @(negedge clk); eng_done = 1'b0; eng_err = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        for (int o = 0; o < 16; o++) rdchk("R12 reset reg", 4'(o), 8'h00);
        chk("R12 irq", {31'd0, irq}, 0);
        chk("R12 req", {31'd0, eng_req}, 0);

        // R1: offset sweep, unmapped writes after mapped ones
        for (int o = 1; o < 16; o++)
            if (o != 2) wr(4'(o), 8'(o * 29 + 7));
        for (int o = 1; o < 16; o++) begin
            logic [7:0] e;
            e = 8'(o * 29 + 7);
            if (o == 13) e = e & 8'h03;
            else if (!(o >= 3 && o <= 7)) e = 8'h00;
            rdchk("R1 readback", 4'(o), e);
        end

        // R2: control read mask
        wr(4'h2, 8'hBD);
        rdchk("R2 ctl mask", 4'h2, 8'h1D);

        // R4 R5 R6 R7 R11: every protocol with both read-flag values
        for (int p = 0; p < 8; p++) begin
            for (int rnw = 0; rnw < 2; rnw++) begin
                logic [7:0] d0w, d1w, bw, ed0, ed1, eb;
                logic [15:0] rv;
                d0w = 8'(8'h10 + p * 2 + rnw);
                d1w = 8'(8'h60 + p);
                bw  = 8'(8'hB0 + p);
                rv  = {8'(8'hC0 | p), 8'(8'h40 | (p << 1) | rnw)};
                wr(4'h4, {7'(7'h50 + p), 1'(rnw)});
                wr(4'h3, 8'(8'h30 + p));
                wr(4'h5, d0w); wr(4'h6, d1w); wr(4'h7, bw);
                wr(4'h0, 8'hFF);
                wr(4'h2, 8'(8'h41 | (p << 2)));
                if (p == 7) begin
                    chk("R7 no req", {31'd0, eng_req}, 0);
                    rdchk("R7 deverr", 4'h0, 8'h04);
                    wr(4'h0, 8'h04);
                end else begin
                    chk("R4 req", {31'd0, eng_req}, 1);
                    chk("R4 proto", {29'd0, eng_proto}, p);
                    chk("R4 taddr", {25'd0, eng_taddr}, 32'(7'h50 + p));
                    chk("R4 rnw", {31'd0, eng_rnw}, (p == 6) ? 1 : rnw);
                    chk("R4 cmd", {24'd0, eng_cmd}, 32'(8'h30 + p));
                    chk("R4 wdata", {16'd0, eng_wdata}, {16'd0, d1w, d0w});
                    chk("R4 blk", {24'd0, eng_blk}, {24'd0, bw});
                    rdchk("R4 busy", 4'h0, 8'h01);
                    respond(1'b0, rv);
                    rdchk("R5 done", 4'h0, (p == 5 || p == 6) ? 8'h82 : 8'h02);
                    chk("R11 irq on", {31'd0, irq}, 1);
                    ed0 = d0w; ed1 = d1w; eb = bw;
                    if ((p == 1 || p == 2) && rnw == 1) ed0 = rv[7:0];
                    if ((p == 3 && rnw == 1) || p == 4) begin ed0 = rv[7:0]; ed1 = rv[15:8]; end
                    if ((p == 5 && rnw == 1) || p == 6) begin ed0 = rv[15:8]; eb = rv[7:0]; end
                    rdchk("R6 data0", 4'h5, ed0);
                    rdchk("R6 data1", 4'h6, ed1);
                    rdchk("R6 blk", 4'h7, eb);
                end
            end
        end

        // R5 R8: error answer, then refused start
        wr(4'h0, 8'hFF);
        wr(4'h2, 8'h41);
        respond(1'b1, 16'h0);
        rdchk("R5 err", 4'h0, 8'h04);
        wr(4'h2, 8'h41);
        chk("R8 no req", {31'd0, eng_req}, 0);
        rdchk("R8 deverr kept", 4'h0, 8'h04);
        wr(4'h0, 8'h04);
        rdchk("R3 deverr cleared", 4'h0, 8'h00);

        // R3: busy survives a full clear; set wins against clear
        wr(4'h2, 8'h41);
        wr(4'h0, 8'hFF);
        rdchk("R3 busy kept", 4'h0, 8'h01);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 8'h02;
        eng_done = 1'b1; eng_rdata = 16'h0;
        @(negedge clk);
        reg_wr = 1'b0; eng_done = 1'b0;
        rdchk("R3 set wins", 4'h0, 8'h02);
        wr(4'h0, 8'hFD);
        rdchk("R3 selective clear", 4'h0, 8'h02);
        wr(4'h0, 8'h02);
        rdchk("R3 cleared", 4'h0, 8'h00);

        // R13: second start while outstanding
        wr(4'h2, 8'h41);
        wr(4'h2, 8'h45);
        chk("R13 no new req", {31'd0, eng_req}, 0);
        chk("R13 proto held", {29'd0, eng_proto}, 0);
        respond(1'b0, 16'h0);
        rdchk("R13 done", 4'h0, 8'h02);

        // R9 R11: deferred start runs on the status read
        wr(4'h0, 8'hFF);
        wr(4'h2, 8'h48);
        chk("R9 no req yet", {31'd0, eng_req}, 0);
        rd(4'h0, v);
        chk("R9 read busy", {24'd0, v}, 32'h01);
        chk("R9 req after read", {31'd0, eng_req}, 1);
        chk("R9 proto", {29'd0, eng_proto}, 2);
        respond(1'b0, 16'h1234);
        rdchk("R9 done", 4'h0, 8'h02);
        chk("R11 irq gated", {31'd0, irq}, 0);
        rdchk("R6 deferred data0", 4'h5, 8'h34);
        wr(4'h2, 8'h01);
        chk("R11 irq enabled", {31'd0, irq}, 1);
        wr(4'h0, 8'hFF);
        chk("R11 irq cleared", {31'd0, irq}, 0);

        // R8 R9: deferred start refused by device error
        wr(4'h2, 8'h5D);
        wr(4'h2, 8'h48);
        rd(4'h0, v);
        chk("R9 read shows busy+err", {24'd0, v}, 32'h05);
        chk("R8 deferred refused", {31'd0, eng_req}, 0);
        rdchk("R8 busy dropped", 4'h0, 8'h04);

        // R10: kill an outstanding request, late answer ignored
        wr(4'h0, 8'hFF);
        wr(4'h2, 8'h41);
        wr(4'h2, 8'h02);
        chk("R10 abort", {31'd0, eng_abort}, 1);
        rdchk("R10 failed", 4'h0, 8'h10);
        respond(1'b0, 16'hFFFF);
        rdchk("R10 late ignored", 4'h0, 8'h10);
        // R10: kill with start in one write
        wr(4'h0, 8'hFF);
        wr(4'h2, 8'h43);
        chk("R10 kill beats start", {31'd0, eng_req}, 0);
        rdchk("R10 kill+start status", 4'h0, 8'h10);
        // R10: kill cancels a pending deferred start
        wr(4'h0, 8'hFF);
        wr(4'h2, 8'h40);
        wr(4'h2, 8'h02);
        rdchk("R10 pending cancelled", 4'h0, 8'h10);
        chk("R10 no req after read", {31'd0, eng_req}, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule